// File: doc/BRIEF.md
# Page-Mode Dynamic Memory with Row Buffer

This block is a behavioural, fully synchronous model of a dynamic memory that has one bank of row latches. Row and column addresses share one address port. Raising the row strobe opens a row: the whole 4096-bit row is copied from the cell array into the latches in a single cycle. While the row stays open, each column strobe moves one byte between the data port and the latches. No new row selection is needed. When the row strobe drops, the latched row, including any writes, is stored back into the array.

The column can be given explicitly, or in burst mode it is taken from an internal counter. The counter steps by one after every accepted access and wraps within the row. This lets a host stream a block of bytes without supplying each address. A refresh timer raises a request at a fixed interval. The request is serviced in the first idle cycle with no row open, by reading one row and storing it back unchanged. A column strobe that finds no open row does nothing except pulse an error flag.

Top module: `pgd_core`

## Requirements
- R1: While reset is held, and on its release, `rdata_valid`, `col_err` and `refresh_req` are 0.
- R2: With no row open, a cycle in which `row_stb` is 1 opens the row given by `addr[ROW_AW-1:0]`. All 512 bytes of that row are captured into the latches, and column strobes are accepted from the next cycle on.
- R3: An accepted read (`col_stb`=1, `we`=0, `burst`=0) of column `addr[8:0]` drives that byte on `rdata`, with `rdata_valid` high for one cycle, in the cycle after the strobe.
- R4: An accepted write (`we`=1) stores `wdata` in the open row's latch at the selected column. A later read of that column in the same open row returns the new byte.
- R5: Lowering `row_stb` closes the row and writes every latched byte back to the array, so reopening the row later returns the written data.
- R6: When `burst`=1, the column is taken from a counter and `addr` is ignored. The counter is 0 right after a row opens, and becomes (column used + 1) after every accepted access, burst or not.
- R7: The burst counter wraps from 511 to 0 inside the open row.
- R8: A column strobe while no row is open, or while `row_stb` is 0, changes no stored byte and gives no `rdata_valid`. It makes `col_err` 1 for exactly the next cycle.
- R9: `refresh_req` rises REFRESH_INTERVAL cycles after the internal reset releases, or after the previous service. It stays high while a row is open or `row_stb` is 1.
- R10: A pending refresh is serviced in a cycle with no row open and `row_stb` at 0. `refresh_req` falls on that edge, and stored data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| row_stb | input | 1 | Row strobe level; high opens a row, low closes it |
| col_stb | input | 1 | Column strobe, one access per cycle it is high |
| we | input | 1 | 1 = write byte, 0 = read byte |
| burst | input | 1 | 1 = column from the burst counter, 0 = column from `addr` |
| addr | input | ADDR_W (9) | Shared row/column address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte |
| rdata_valid | output | 1 | One-cycle read data valid |
| col_err | output | 1 | One-cycle flag for a column strobe without an open row |
| refresh_req | output | 1 | Pending refresh request |

## Verification
The hardest state to reach is a refresh request that is pending while a row is held open, followed by the service in the idle cycle after the row closes. The bench gets there right after reset: it holds the row strobe high, counts cycles until the request rises, and keeps it pending for several more cycles. It then closes the row and checks the exact edge on which the request falls, and later confirms that the data survived. A second hard corner is a burst that crosses column 511; it is reached by a directed explicit access to 511 followed by burst accesses.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BYTE_SH = $clog2(BYTE_W);
endpackage

// File: rtl/pgd_cell_array.sv
module pgd_cell_array #(
  parameter int unsigned NUM_ROWS = 4,
  parameter int unsigned ROW_BITS = 4096,
  localparam int unsigned ROW_AW  = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic [ROW_AW-1:0]   rd_row,
  output logic [ROW_BITS-1:0] rd_vec,
  input  logic                st_en,
  input  logic [ROW_AW-1:0]   st_row,
  input  logic [ROW_BITS-1:0] st_vec
);
  logic [ROW_BITS-1:0] cells [NUM_ROWS];

  assign rd_vec = cells[rd_row];

  always_ff @(posedge clk) begin
    if (st_en) cells[st_row] <= st_vec;
  end
endmodule

// File: rtl/pgd_row_latch.sv
module pgd_row_latch
  import pgd_pkg::*;
#(
  parameter int unsigned ROW_BITS = 4096,
  localparam int unsigned COL_AW  = $clog2(ROW_BITS / BYTE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [ROW_BITS-1:0] load_vec,
  input  logic                acc_en,
  input  logic                acc_we,
  input  logic [COL_AW-1:0]   acc_col,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [ROW_BITS-1:0] vec,
  output logic [BYTE_W-1:0]   rdata,
  output logic                rvalid
);
  logic [ROW_BITS-1:0]      lat_q;
  logic [COL_AW+BYTE_SH-1:0] bit_base;
  logic [BYTE_W-1:0]        rdata_d, rdata_q;
  logic                     rvalid_d, rvalid_q;
  logic                     rd_en;

  assign bit_base = {acc_col, {BYTE_SH{1'b0}}};
  assign rd_en    = acc_en && !acc_we;

  // data latches: no reset, loaded on row open or byte write
  always_ff @(posedge clk) begin
    if (load_en) lat_q <= load_vec;
    else if (acc_en && acc_we) lat_q[bit_base +: BYTE_W] <= wdata;
  end

  always_comb begin
    rvalid_d = rd_en;
    rdata_d  = rdata_q;
    if (rd_en) rdata_d = lat_q[bit_base +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign vec    = lat_q;
  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/pgd_col_unit.sv
module pgd_col_unit #(
  parameter int unsigned COL_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_open,
  input  logic              row_stb,
  input  logic              open_evt,
  input  logic              col_stb,
  input  logic              burst,
  input  logic [COL_AW-1:0] addr_col,
  output logic              col_ok,
  output logic [COL_AW-1:0] col_sel,
  output logic              col_err
);
  logic [COL_AW-1:0] ctr_d, ctr_q;
  logic              err_d, err_q;

  assign col_ok  = col_stb && row_open && row_stb;
  assign col_sel = burst ? ctr_q : addr_col;

  always_comb begin
    ctr_d = ctr_q;
    if (open_evt)    ctr_d = '0;
    else if (col_ok) ctr_d = col_sel + 1'b1;
    err_d = col_stb && !(row_open && row_stb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
      err_q <= 1'b0;
    end else begin
      ctr_q <= ctr_d;
      err_q <= err_d;
    end
  end

  assign col_err = err_q;
endmodule

// File: rtl/pgd_refresh_timer.sv
module pgd_refresh_timer #(
  parameter int unsigned INTERVAL = 1000,
  parameter int unsigned ROW_AW   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc,
  output logic              req,
  output logic [ROW_AW-1:0] ptr
);
  localparam int unsigned CNT_W = $clog2(INTERVAL + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0]  cnt_d, cnt_q;
  logic              req_d, req_q;
  logic [ROW_AW-1:0] ptr_d, ptr_q;

  always_comb begin
    cnt_d = cnt_q;
    req_d = req_q;
    ptr_d = ptr_q;
    if (svc) begin
      req_d = 1'b0;
      cnt_d = '0;
      ptr_d = ptr_q + 1'b1;
    end else if (!req_q) begin
      if (cnt_q == LAST) begin
        req_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
      ptr_q <= ptr_d;
    end
  end

  assign req = req_q;
  assign ptr = ptr_q;
endmodule

// File: rtl/pgd_core.sv
module pgd_core
  import pgd_pkg::*;
#(
  parameter int unsigned NUM_ROWS         = 4,
  parameter int unsigned ROW_BITS         = 4096,
  parameter int unsigned REFRESH_INTERVAL = 1000,
  localparam int unsigned ROW_BYTES = ROW_BITS / BYTE_W,
  localparam int unsigned COL_AW    = $clog2(ROW_BYTES),
  localparam int unsigned ROW_AW    = $clog2(NUM_ROWS),
  localparam int unsigned ADDR_W    = (COL_AW > ROW_AW) ? COL_AW : ROW_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb,
  input  logic              col_stb,
  input  logic              we,
  input  logic              burst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              rdata_valid,
  output logic              col_err,
  output logic              refresh_req
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // row state
  logic              row_open_d, row_open_q;
  logic [ROW_AW-1:0] open_row_d, open_row_q;
  logic              open_evt, close_evt, ref_svc;
  logic [ROW_AW-1:0] ref_ptr, arr_rd_row, arr_st_row;
  logic [ROW_BITS-1:0] arr_rd_vec, arr_st_vec, lat_vec;
  logic              arr_st_en;
  logic              col_ok;
  logic [COL_AW-1:0] col_sel;

  assign open_evt  = row_stb && !row_open_q;
  assign close_evt = !row_stb && row_open_q;
  assign ref_svc   = refresh_req && !row_open_q && !row_stb;

  always_comb begin
    row_open_d = row_open_q;
    open_row_d = open_row_q;
    if (open_evt) begin
      row_open_d = 1'b1;
      open_row_d = addr[ROW_AW-1:0];
    end else if (close_evt) begin
      row_open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      row_open_q <= 1'b0;
      open_row_q <= '0;
    end else begin
      row_open_q <= row_open_d;
      open_row_q <= open_row_d;
    end
  end

  // array port steering: refresh and write-back never coincide
  assign arr_rd_row = ref_svc ? ref_ptr : addr[ROW_AW-1:0];
  assign arr_st_en  = close_evt || ref_svc;
  assign arr_st_row = close_evt ? open_row_q : ref_ptr;
  assign arr_st_vec = close_evt ? lat_vec : arr_rd_vec;

  pgd_cell_array #(.NUM_ROWS(NUM_ROWS), .ROW_BITS(ROW_BITS)) u_array (
    .clk    (clk),
    .rd_row (arr_rd_row),
    .rd_vec (arr_rd_vec),
    .st_en  (arr_st_en),
    .st_row (arr_st_row),
    .st_vec (arr_st_vec)
  );

  pgd_row_latch #(.ROW_BITS(ROW_BITS)) u_latch (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_en  (open_evt),
    .load_vec (arr_rd_vec),
    .acc_en   (col_ok),
    .acc_we   (we),
    .acc_col  (col_sel),
    .wdata    (wdata),
    .vec      (lat_vec),
    .rdata    (rdata),
    .rvalid   (rdata_valid)
  );

  pgd_col_unit #(.COL_AW(COL_AW)) u_col (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .row_open (row_open_q),
    .row_stb  (row_stb),
    .open_evt (open_evt),
    .col_stb  (col_stb),
    .burst    (burst),
    .addr_col (addr[COL_AW-1:0]),
    .col_ok   (col_ok),
    .col_sel  (col_sel),
    .col_err  (col_err)
  );

  pgd_refresh_timer #(.INTERVAL(REFRESH_INTERVAL), .ROW_AW(ROW_AW)) u_ref (
    .clk   (clk),
    .rst_n (rst_core_n),
    .svc   (ref_svc),
    .req   (refresh_req),
    .ptr   (ref_ptr)
  );
endmodule

// File: rtl/pgd_core_chk.sv
module pgd_core_chk (
  input logic clk,
  input logic rst_core_n,
  input logic row_stb,
  input logic col_stb,
  input logic we,
  input logic row_open,
  input logic rdata_valid,
  input logic col_err,
  input logic refresh_req
);
  // R8: strobe without an open row flags an error next cycle
  a_r8_err_on_orphan: assert property (@(posedge clk) disable iff (!rst_core_n)
    (col_stb && !row_open) |=> col_err);

  // R8: an error cycle never carries read data
  a_r8_no_valid_on_err: assert property (@(posedge clk) disable iff (!rst_core_n)
    col_err |-> !rdata_valid);

  // R3: accepted read returns data one cycle later
  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_core_n)
    (col_stb && !we && row_open && row_stb) |=> rdata_valid);

  // R2: a row only opens while the row strobe is high
  a_r2_open_needs_strobe: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(row_open) |-> $past(row_stb));

  // R9: pending request held while a row is open
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_core_n)
    (refresh_req && row_open) |=> refresh_req);

  // R10: service only in an idle cycle
  a_r10_idle_service: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(refresh_req) |-> (!$past(row_open) && !$past(row_stb)));
endmodule

bind pgd_core pgd_core_chk u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .row_stb     (row_stb),
  .col_stb     (col_stb),
  .we          (we),
  .row_open    (row_open_q),
  .rdata_valid (rdata_valid),
  .col_err     (col_err),
  .refresh_req (refresh_req)
);

// File: tb/sim_pgd_core.sv
module sim_pgd_core;
  localparam int INTERVAL = 300;
  localparam int NROWS    = 4;
  localparam int NCOLS    = 512;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       row_stb, col_stb, we, burst;
  logic [8:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       rdata_valid, col_err, refresh_req;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  logic [7:0] model [NROWS][NCOLS];
  int cur_row = 0;
  int bc = 0;

  always #10 clk = ~clk;

  pgd_core #(.NUM_ROWS(NROWS), .ROW_BITS(4096), .REFRESH_INTERVAL(INTERVAL)) u0 (
    .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .col_stb(col_stb), .we(we),
    .burst(burst), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_valid(rdata_valid), .col_err(col_err), .refresh_req(refresh_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int next_col(input bit b, input int c);
    return b ? bc : c;
  endfunction

  task automatic open_row(input int r);
    row_stb = 1'b1;
    addr = 9'(r);
    @(negedge clk);
    cur_row = r;
    bc = 0;
  endtask

  task automatic close_row();
    row_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic access(input bit w, input bit b, input int c, input logic [7:0] d,
                        input bit check, input string tag);
    int col;
    col = next_col(b, c);
    col_stb = 1'b1; we = w; burst = b; addr = 9'(c); wdata = d;
    @(negedge clk);
    col_stb = 1'b0; we = 1'b0; burst = 1'b0;
    bc = (col + 1) % NCOLS;
    if (w) model[cur_row][col] = d;
    else if (check)
      chk(rdata_valid === 1'b1 && rdata === model[cur_row][col], tag,
          {rdata_valid, rdata}, {1'b1, model[cur_row][col]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    rst_n = 1'b0; row_stb = 1'b0; col_stb = 1'b0; we = 1'b0; burst = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(rdata_valid === 1'b0 && col_err === 1'b0 && refresh_req === 1'b0, "R1",
        {rdata_valid, col_err, refresh_req}, 0);
    rst_n = 1'b1;

    // R9: refresh request timing while a row is held open
    row_stb = 1'b1; addr = 9'd0;
    n = 0;
    while (refresh_req !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n == INTERVAL + 2, "R9", n, INTERVAL + 2);
    cur_row = 0; bc = 0;
    repeat (5) @(negedge clk);
    chk(refresh_req === 1'b1, "R9", refresh_req, 1);
    row_stb = 1'b0;
    @(negedge clk);
    chk(refresh_req === 1'b1, "R10", refresh_req, 1);
    @(negedge clk);
    chk(refresh_req === 1'b0, "R10", refresh_req, 0);

    // fill every row: one explicit write then a burst
    for (int r = 0; r < NROWS; r++) begin
      open_row(r);
      access(1'b1, 1'b0, 0, 8'($urandom), 1'b0, "init");
      for (int c = 1; c < NCOLS; c++) access(1'b1, 1'b1, 0, 8'($urandom), 1'b0, "init");
      close_row();
    end

    // R2: row captured on open
    open_row(2);
    access(1'b0, 1'b0, 7, 8'h00, 1'b1, "R2");
    access(1'b0, 1'b0, 300, 8'h00, 1'b1, "R3");
    // R4: write then read back inside the open row
    access(1'b1, 1'b0, 9, 8'h3C, 1'b0, "R4");
    access(1'b0, 1'b0, 9, 8'h00, 1'b1, "R4");
    // R7: burst wrap
    access(1'b0, 1'b0, 511, 8'h00, 1'b1, "R3");
    access(1'b0, 1'b1, 77, 8'h00, 1'b1, "R7");
    access(1'b0, 1'b1, 77, 8'h00, 1'b1, "R6");
    close_row();

    // R5: write-back survives another row's use
    open_row(3);
    access(1'b1, 1'b0, 100, 8'hA5, 1'b0, "R5");
    close_row();
    open_row(0);
    access(1'b0, 1'b0, 100, 8'h00, 1'b1, "R3");
    close_row();
    open_row(3);
    access(1'b0, 1'b0, 100, 8'h00, 1'b1, "R5");
    close_row();

    // R8: strobe with no row open
    col_stb = 1'b1; we = 1'b1; addr = 9'd5; wdata = ~model[3][5];
    @(negedge clk);
    col_stb = 1'b0; we = 1'b0;
    chk(col_err === 1'b1 && rdata_valid === 1'b0, "R8", {col_err, rdata_valid}, 2);
    @(negedge clk);
    chk(col_err === 1'b0, "R8", col_err, 0);
    open_row(3);
    access(1'b0, 1'b0, 5, 8'h00, 1'b1, "R8");
    close_row();

    // R10: idle long enough for several refreshes, data intact
    repeat (3 * INTERVAL) @(negedge clk);
    for (int r = 0; r < NROWS; r++) begin
      open_row(r);
      access(1'b0, 1'b0, 5 + r, 8'h00, 1'b1, "R10");
      close_row();
    end

    // random mix
    for (int k = 0; k < 150; k++) begin
      open_row(int'($urandom % NROWS));
      for (int j = 0; j < 1 + int'($urandom % 12); j++) begin
        bit w, b;
        w = 1'($urandom % 2);
        b = ($urandom % 3) == 0;
        access(w, b, int'($urandom % NCOLS), 8'($urandom), 1'b1, b ? "R6" : "R3");
      end
      close_row();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule